// File: doc/BRIEF.md
# Dead-Band Edge Delay Generator

This block sits between a PWM waveform source and a pair of gate-drive outputs. It inserts dead time by holding back the rising edges on one path and the falling edges on the other. Each delay is a whole number of time-base clocks. Either path can take its input from channel A or channel B. The two delayed signals then go through a polarity stage, which can invert either one, and a swap stage, which can route either one to either output. Together these give the usual active-high, active-low and complementary drive schemes. When the block is disabled, both inputs pass to the outputs with one register of latency.

Each delay value has an active copy and a shadow copy. In immediate mode, a write goes to the active copy at once. In shadow mode, a write lands in the shadow copy. It moves to the active copy only on the load event chosen for that delay: counter-equals-zero, counter-equals-period, either one, or never (frozen). The counter strobes come from a time-base counter outside the block. A delay count keeps the value it captured at the edge that started it.

All control pins are plain levels sampled on the rising clock edge. No data stream crosses this block, so it has no valid/ready handshake and no back-pressure.

Top module: `deadband_gen`

## Requirements
- R1: `in_sel[0]` picks the source of the rising-delay path (0 = A, 1 = B). `in_sel[1]` picks the source of the falling-delay path (0 = A, 1 = B). With `in_sel` = 00, channel A feeds both paths.
- R2: With `out_en` = 1 and rising delay D, suppose the source is first sampled high at edge k. The rising-path signal then goes high after edge k+D. It goes low after the first edge that samples the source low.
- R3: With falling delay D, suppose the source is first sampled low at edge k. The falling-path signal then goes low after edge k+D. It goes high after the first edge that samples the source high.
- R4: With both delays at zero, both path signals follow their sources one clock later.
- R5: If the source returns to its idle level before a delay count ends, the pending edge is dropped and no output pulse appears. The next qualifying edge starts a fresh count of the full delay.
- R6: `pol_sel[0]` inverts the rising path and `pol_sel[1]` inverts the falling path. This gives 00 = active high, 01 = active-low complementary, 10 = active-high complementary, and 11 = active low. In mode 10 with a shared source, `out_a` and `out_b` are never high together.
- R7: If `swap_sel[0]` = 1, `out_a` carries the falling-path signal instead of the rising-path signal. If `swap_sel[1]` = 1, `out_b` carries the rising-path signal instead of the falling-path signal.
- R8: With `out_en` = 0, `out_a` and `out_b` equal `pwm_a_in` and `pwm_b_in` as sampled at the previous edge. Delay, polarity and swap settings have no effect.
- R9: In shadow mode, the load selector decides when the shadow value moves to the active delay: 00 = `ctr_zero`, 01 = `ctr_prd`, 10 = either strobe, 11 = never.
- R10: With the shadow enable low, a write sets the active delay at the writing edge. With the shadow enable high, a write changes only the shadow copy.
- R11: After reset, both active delays are zero and, in active-high mode, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Time-base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctr_zero | input | 1 | Counter-equals-zero strobe |
| ctr_prd | input | 1 | Counter-equals-period strobe |
| pwm_a_in | input | 1 | Raw PWM channel A |
| pwm_b_in | input | 1 | Raw PWM channel B |
| out_en | input | 1 | 1 = dead-band path, 0 = registered bypass |
| in_sel | input | 2 | Source select for the rising and falling paths |
| pol_sel | input | 2 | Per-path inversion |
| swap_sel | input | 2 | Output swap control |
| rise_shadow_en | input | 1 | Shadow mode for the rising delay |
| rise_load_sel | input | 2 | Load event for the rising delay |
| rise_wr_en | input | 1 | Rising delay write strobe |
| rise_wr_data | input | DLY_W | Rising delay value in clocks |
| fall_shadow_en | input | 1 | Shadow mode for the falling delay |
| fall_load_sel | input | 2 | Load event for the falling delay |
| fall_wr_en | input | 1 | Falling delay write strobe |
| fall_wr_data | input | DLY_W | Falling delay value in clocks |
| out_a | output | 1 | Output A |
| out_b | output | 1 | Output B |

## Verification
A wrong active delay value shows at the ports as an output edge that lands one or more clocks away from the expected position. This appears at the very next qualifying input edge, at most D+1 clocks after that edge. A counter that fails to clear when a short pulse ends shows as a spurious output pulse that has no matching input pulse. A premature shadow transfer makes the measured delay change before the selected strobe arrives. A wrong polarity or swap setting shows as an inverted or misrouted level within one clock of a steady input.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    LD_ZERO   = 2'b00,
    LD_PRD    = 2'b01,
    LD_EITHER = 2'b10,
    LD_FREEZE = 2'b11
  } load_sel_e;

  function automatic logic load_hit(input load_sel_e sel, input logic z, input logic p);
    case (sel)
      LD_ZERO:   load_hit = z;
      LD_PRD:    load_hit = p;
      LD_EITHER: load_hit = z | p;
      default:   load_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dbg_delay_reg.sv
module dbg_delay_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_zero,
  input  logic         ev_prd,
  input  logic         shadow_en,
  input  logic [1:0]   load_sel,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] act_q,
  output logic [W-1:0] shd_q
);
  import dbg_pkg::*;

  logic xfer;
  assign xfer = shadow_en & load_hit(load_sel_e'(load_sel), ev_zero, ev_prd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      shd_q <= '0;
    end else begin
      if (wr_en) shd_q <= wr_data;
      if (!shadow_en) begin
        if (wr_en) act_q <= wr_data;
      end else if (xfer) begin
        act_q <= shd_q;
      end
    end
  end
endmodule

// File: rtl/dbg_edge_delay.sv
module dbg_edge_delay #(
  parameter int   W      = 10,
  parameter logic INVERT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src,
  input  logic [W-1:0] dly,
  output logic         sig
);
  logic         lvl;
  logic         hold_q;
  logic         busy_q;
  logic [W-1:0] cnt_q;

  assign lvl = src ^ INVERT;
  assign sig = hold_q ^ INVERT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= INVERT;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!lvl) begin
      hold_q <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!hold_q) begin
      if (!busy_q) begin
        if (dly == '0) begin
          hold_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= dly - 1'b1;
        end
      end else if (cnt_q == '0) begin
        hold_q <= 1'b1;
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbg_out_map.sv
module dbg_out_map (
  input  logic       en,
  input  logic [1:0] pol,
  input  logic [1:0] swap,
  input  logic       rise_sig,
  input  logic       fall_sig,
  input  logic       raw_a,
  input  logic       raw_b,
  output logic       o_a,
  output logic       o_b
);
  logic pa, pb;
  always_comb begin
    pa = rise_sig ^ pol[0];
    pb = fall_sig ^ pol[1];
    if (en) begin
      o_a = swap[0] ? pb : pa;
      o_b = swap[1] ? pa : pb;
    end else begin
      o_a = raw_a;
      o_b = raw_b;
    end
  end
endmodule

// File: rtl/deadband_gen.sv
module deadband_gen #(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctr_zero,
  input  logic             ctr_prd,
  input  logic             pwm_a_in,
  input  logic             pwm_b_in,
  input  logic             out_en,
  input  logic [1:0]       in_sel,
  input  logic [1:0]       pol_sel,
  input  logic [1:0]       swap_sel,
  input  logic             rise_shadow_en,
  input  logic [1:0]       rise_load_sel,
  input  logic             rise_wr_en,
  input  logic [DLY_W-1:0] rise_wr_data,
  input  logic             fall_shadow_en,
  input  logic [1:0]       fall_load_sel,
  input  logic             fall_wr_en,
  input  logic [DLY_W-1:0] fall_wr_data,
  output logic             out_a,
  output logic             out_b
);
  localparam int NPATH = 2;

  logic             p_src    [NPATH];
  logic             p_sh     [NPATH];
  logic [1:0]       p_ld     [NPATH];
  logic             p_we     [NPATH];
  logic [DLY_W-1:0] p_wd     [NPATH];
  logic [DLY_W-1:0] p_act    [NPATH];
  logic [DLY_W-1:0] p_shd    [NPATH];
  logic             p_sig    [NPATH];

  // path 0 delays rising edges, path 1 delays falling edges
  assign p_src[0] = in_sel[0] ? pwm_b_in : pwm_a_in;
  assign p_src[1] = in_sel[1] ? pwm_b_in : pwm_a_in;
  assign p_sh[0]  = rise_shadow_en;
  assign p_sh[1]  = fall_shadow_en;
  assign p_ld[0]  = rise_load_sel;
  assign p_ld[1]  = fall_load_sel;
  assign p_we[0]  = rise_wr_en;
  assign p_we[1]  = fall_wr_en;
  assign p_wd[0]  = rise_wr_data;
  assign p_wd[1]  = fall_wr_data;

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    dbg_delay_reg #(.W(DLY_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_zero  (ctr_zero),
      .ev_prd   (ctr_prd),
      .shadow_en(p_sh[g]),
      .load_sel (p_ld[g]),
      .wr_en    (p_we[g]),
      .wr_data  (p_wd[g]),
      .act_q    (p_act[g]),
      .shd_q    (p_shd[g])
    );
    dbg_edge_delay #(.W(DLY_W), .INVERT(g == 1)) u_dly (
      .clk  (clk),
      .rst_n(rst_n),
      .src  (p_src[g]),
      .dly  (p_act[g]),
      .sig  (p_sig[g])
    );
  end

  logic             rise_src, fall_src, rise_y, fall_y;
  logic [DLY_W-1:0] rise_act, rise_shd, fall_act;
  assign rise_src = p_src[0];
  assign fall_src = p_src[1];
  assign rise_y   = p_sig[0];
  assign fall_y   = p_sig[1];
  assign rise_act = p_act[0];
  assign rise_shd = p_shd[0];
  assign fall_act = p_act[1];

  logic a_q, b_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= pwm_a_in;
      b_q <= pwm_b_in;
    end
  end

  dbg_out_map u_map (
    .en      (out_en),
    .pol     (pol_sel),
    .swap    (swap_sel),
    .rise_sig(rise_y),
    .fall_sig(fall_y),
    .raw_a   (a_q),
    .raw_b   (b_q),
    .o_a     (out_a),
    .o_b     (out_b)
  );
endmodule

// File: rtl/dbg_checker.sv
module dbg_checker #(
  parameter int DLY_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctr_zero,
  input logic             pwm_a_in,
  input logic             out_en,
  input logic [1:0]       in_sel,
  input logic [1:0]       pol_sel,
  input logic [1:0]       swap_sel,
  input logic             rise_shadow_en,
  input logic [1:0]       rise_load_sel,
  input logic             rise_wr_en,
  input logic [DLY_W-1:0] rise_wr_data,
  input logic             rise_src,
  input logic             fall_src,
  input logic             rise_y,
  input logic             fall_y,
  input logic [DLY_W-1:0] rise_act,
  input logic [DLY_W-1:0] rise_shd,
  input logic             out_a,
  input logic             out_b
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_rise_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(rise_y)) |-> $past(rise_src));
  assert_rise_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(rise_y)) |-> !$past(rise_src));
  assert_fall_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $fell(fall_y)) |-> !$past(fall_src));
  assert_fall_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(fall_y)) |-> $past(fall_src));
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && out_en && pol_sel == 2'b10 && swap_sel == 2'b00 && $past(in_sel) == 2'b00)
      |-> !(out_a && out_b));
  assert_bypass_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !out_en) |-> (out_a == $past(pwm_a_in)));
  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_shadow_en && rise_load_sel == 2'b11) |=> $stable(rise_act));
  assert_zero_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_shadow_en && rise_load_sel == 2'b00 && ctr_zero) |=> (rise_act == $past(rise_shd)));
  assert_direct_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_shadow_en && rise_wr_en) |=> (rise_act == $past(rise_wr_data)));
endmodule

bind deadband_gen dbg_checker #(.DLY_W(DLY_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctr_zero      (ctr_zero),
  .pwm_a_in      (pwm_a_in),
  .out_en        (out_en),
  .in_sel        (in_sel),
  .pol_sel       (pol_sel),
  .swap_sel      (swap_sel),
  .rise_shadow_en(rise_shadow_en),
  .rise_load_sel (rise_load_sel),
  .rise_wr_en    (rise_wr_en),
  .rise_wr_data  (rise_wr_data),
  .rise_src      (rise_src),
  .fall_src      (fall_src),
  .rise_y        (rise_y),
  .fall_y        (fall_y),
  .rise_act      (rise_act),
  .rise_shd      (rise_shd),
  .out_a         (out_a),
  .out_b         (out_b)
);

// File: tb/sim_deadband_gen.sv
`timescale 1ns/1ps
module sim_deadband_gen;
  localparam int DW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctr_zero = 0, ctr_prd = 0, a = 0, b = 0, out_en = 1;
  logic [1:0] in_sel = 0, pol_sel = 0, swap_sel = 0;
  logic rise_sh = 0, rise_we = 0, fall_sh = 0, fall_we = 0;
  logic [1:0] rise_ld = 0, fall_ld = 0;
  logic [DW-1:0] rise_wd = 0, fall_wd = 0;
  logic out_a, out_b;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  deadband_gen #(.DLY_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctr_zero(ctr_zero), .ctr_prd(ctr_prd),
    .pwm_a_in(a), .pwm_b_in(b), .out_en(out_en), .in_sel(in_sel),
    .pol_sel(pol_sel), .swap_sel(swap_sel),
    .rise_shadow_en(rise_sh), .rise_load_sel(rise_ld), .rise_wr_en(rise_we), .rise_wr_data(rise_wd),
    .fall_shadow_en(fall_sh), .fall_load_sel(fall_ld), .fall_wr_en(fall_we), .fall_wr_data(fall_wd),
    .out_a(out_a), .out_b(out_b));

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_base();
    out_en = 1; in_sel = 0; pol_sel = 0; swap_sel = 0; b = 0;
  endtask

  task automatic set_rise(int v);
    rise_sh = 0; rise_we = 1; rise_wd = DW'(v); tick(); rise_we = 0;
  endtask

  task automatic set_fall(int v);
    fall_sh = 0; fall_we = 1; fall_wd = DW'(v); tick(); fall_we = 0;
  endtask

  task automatic measure_rise(output int n);
    a = 0; repeat (3) tick();
    a = 1; n = 0; tick();
    while (out_a !== 1'b1 && n < 100) begin n++; tick(); end
    a = 0; tick();
  endtask

  task automatic t_reset();
    chk("R11", "out_a after reset", out_a, 0);
    chk("R11", "out_b after reset", out_b, 0);
    begin int n; measure_rise(n); chk("R11", "reset rise delay", n, 0); end
  endtask

  task automatic t_zero();
    cfg_base(); set_rise(0); set_fall(0);
    a = 0; tick(); a = 1; tick();
    chk("R4", "out_a one clock after rise", out_a, 1);
    chk("R4", "out_b one clock after rise", out_b, 1);
    a = 0; tick();
    chk("R4", "out_a one clock after fall", out_a, 0);
    chk("R4", "out_b one clock after fall", out_b, 0);
  endtask

  task automatic t_rise();
    cfg_base(); set_rise(5); set_fall(0);
    a = 0; repeat (3) tick();
    a = 1; repeat (5) tick();
    chk("R2", "out_a still low at D", out_a, 0);
    chk("R2", "out_b undelayed rise", out_b, 1);
    tick();
    chk("R2", "out_a high at D+1", out_a, 1);
    a = 0; tick();
    chk("R2", "out_a falls undelayed", out_a, 0);
  endtask

  task automatic t_fall();
    cfg_base(); set_rise(0); set_fall(7);
    a = 1; repeat (3) tick();
    chk("R3", "out_b high while input high", out_b, 1);
    a = 0; repeat (7) tick();
    chk("R3", "out_b still high at D", out_b, 1);
    tick();
    chk("R3", "out_b low at D+1", out_b, 0);
    chk("R3", "out_a low", out_a, 0);
  endtask

  task automatic t_absorb();
    int hi;
    cfg_base(); set_rise(6); set_fall(5);
    a = 0; repeat (8) tick();
    a = 1; hi = 0;
    repeat (3) begin tick(); hi |= out_a; end
    a = 0; tick(); hi |= out_a;
    chk("R5", "short high pulse absorbed", hi, 0);
    a = 1; repeat (6) tick();
    chk("R5", "restarted count not done", out_a, 0);
    tick();
    chk("R5", "restarted count full delay", out_a, 1);
    repeat (8) tick();
    a = 0; hi = 1;
    repeat (2) begin tick(); hi &= out_b; end
    a = 1; repeat (4) begin tick(); hi &= out_b; end
    chk("R5", "short low pulse absorbed on out_b", hi, 1);
  endtask

  task automatic t_pol();
    cfg_base(); set_rise(2); set_fall(3);
    pol_sel = 2'b10; a = 1; repeat (6) tick();
    chk("R6", "AHC high out_a", out_a, 1);
    chk("R6", "AHC high out_b", out_b, 0);
    a = 0; repeat (6) tick();
    chk("R6", "AHC low out_a", out_a, 0);
    chk("R6", "AHC low out_b", out_b, 1);
    a = 1; repeat (6) tick();
    pol_sel = 2'b11; #1;
    chk("R6", "AL out_a", out_a, 0);
    chk("R6", "AL out_b", out_b, 0);
    pol_sel = 2'b01; #1;
    chk("R6", "ALC out_a", out_a, 0);
    chk("R6", "ALC out_b", out_b, 1);
  endtask

  task automatic t_swap();
    cfg_base(); pol_sel = 2'b10; a = 1; repeat (6) tick();
    swap_sel = 2'b11; #1;
    chk("R7", "full swap out_a", out_a, 0);
    chk("R7", "full swap out_b", out_b, 1);
    swap_sel = 2'b01; #1;
    chk("R7", "swap01 out_a", out_a, 0);
    chk("R7", "swap01 out_b", out_b, 0);
    swap_sel = 2'b10; #1;
    chk("R7", "swap10 out_a", out_a, 1);
    chk("R7", "swap10 out_b", out_b, 1);
    a = 0; repeat (6) tick();
  endtask

  task automatic t_route();
    cfg_base(); set_rise(0); set_fall(0);
    in_sel = 2'b01; a = 0; b = 1; tick();
    chk("R1", "rise path from B", out_a, 1);
    chk("R1", "fall path from A", out_b, 0);
    in_sel = 2'b10; a = 1; b = 0; tick();
    chk("R1", "rise path from A", out_a, 1);
    chk("R1", "fall path from B", out_b, 0);
    a = 0; b = 0; tick(); cfg_base();
  endtask

  task automatic t_bypass();
    cfg_base(); set_rise(9); set_fall(9);
    out_en = 0; pol_sel = 2'b11; swap_sel = 2'b11;
    a = 1; b = 0; tick();
    chk("R8", "bypass out_a", out_a, 1);
    chk("R8", "bypass out_b", out_b, 0);
    a = 0; b = 1; tick();
    chk("R8", "bypass out_a low", out_a, 0);
    chk("R8", "bypass out_b high", out_b, 1);
    b = 0; tick(); cfg_base();
  endtask

  task automatic t_shadow();
    int n;
    cfg_base(); set_rise(0); set_fall(0);
    set_rise(3); measure_rise(n);
    chk("R10", "immediate write", n, 3);
    rise_sh = 1; rise_ld = 2'b00; rise_we = 1; rise_wd = 4; tick(); rise_we = 0;
    measure_rise(n);
    chk("R10", "shadow write held", n, 3);
    ctr_prd = 1; tick(); ctr_prd = 0;
    measure_rise(n);
    chk("R9", "zero mode ignores prd", n, 3);
    ctr_zero = 1; tick(); ctr_zero = 0;
    measure_rise(n);
    chk("R9", "load on zero", n, 4);
    rise_ld = 2'b01; rise_we = 1; rise_wd = 2; tick(); rise_we = 0;
    ctr_zero = 1; tick(); ctr_zero = 0;
    measure_rise(n);
    chk("R9", "prd mode ignores zero", n, 4);
    ctr_prd = 1; tick(); ctr_prd = 0;
    measure_rise(n);
    chk("R9", "load on prd", n, 2);
    rise_ld = 2'b11; rise_we = 1; rise_wd = 6; tick(); rise_we = 0;
    ctr_zero = 1; ctr_prd = 1; tick(); ctr_zero = 0; ctr_prd = 0;
    measure_rise(n);
    chk("R9", "freeze blocks load", n, 2);
    rise_ld = 2'b10; ctr_prd = 1; tick(); ctr_prd = 0;
    measure_rise(n);
    chk("R9", "either mode on prd", n, 6);
    rise_sh = 0; rise_ld = 0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset(); t_zero(); t_rise(); t_fall(); t_absorb();
    t_pol(); t_swap(); t_route(); t_bypass(); t_shadow();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule